// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic stage of a small accumulator machine. Each cycle it takes two operands, a 5-bit operation code and a qualifying strobe. It drives the operation's result combinationally, from the operands and the flags it currently holds. On a clock edge where the strobe is high, it writes the new flags into its status byte.

The status byte holds six flags: carry, overflow, zero, negative, interrupt mask and half carry. Its two upper bits always read as 1. The block also gates an active-low interrupt request with the mask flag, so the sequencer sees a single "take interrupt" signal. Instruction decode, sequencing and memory access belong to the surrounding CPU.

Top module: `alu8_ccr`

## Requirements
- R1: After reset the status byte reads 0xD0, so the mask is set and every other flag is clear. Its layout from bit 7 down to bit 0 is 1, 1, H, I, N, Z, V, C.
- R2: ADD (code 0) returns a+b and ADC (code 1) returns a+b+C, both modulo 256. C takes the carry out of bit 7 and H the carry from bit 3 into bit 4. V flags a signed overflow.
- R3: SUB (code 2) returns a-b and SBC (code 3) returns a-b-C. C is set on a borrow, meaning the unsigned subtrahend (plus borrow in) exceeds the minuend, and V flags a signed overflow. H is unchanged.
- R4: INC (code 4) returns a+1 and DEC (code 5) returns a-1. V is set only when INC gets 0x7F or DEC gets 0x80. C and H are unchanged.
- R5: AND, OR, XOR and NOT of a (codes 6 to 9) clear V and leave C and H unchanged.
- R6: SHL (code 10) shifts in 0 at bit 0, SHR (code 11) shifts in 0 at bit 7, and ASR (code 12) copies bit 7. C takes the bit shifted out and V becomes N xor C.
- R7: ROL (code 13) and ROR (code 14) rotate through the carry: the old C enters at the vacated end and the bit leaving becomes the new C. V becomes N xor C.
- R8: Codes 15 to 20 clear C, set C, clear V, set V, clear I and set I in that order. No other flag changes.
- R9: TAP (code 21) loads the six flags from a[5:0]. TPA (code 22) returns the status byte as its result and leaves the flags unchanged.
- R10: The status byte holds its value on any cycle with the strobe low, and on codes 23 to 31.
- R11: int_mask_o equals I, and int_req_o is high exactly when irq_n_i is low and I is clear.
- R12: Status bits 7 and 6 read as 1 even after TAP loads zeros. For every data operation (codes 0 to 14), N is bit 7 of the result and Z is set exactly when the result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid_i | input | 1 | Commit this cycle's flags on the clock edge |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | First operand |
| b_i | input | 8 | Second operand |
| irq_n_i | input | 1 | Active-low interrupt request |
| result_o | output | 8 | Operation result (combinational) |
| ccr_o | output | 8 | Status byte |
| int_mask_o | output | 1 | Interrupt mask flag |
| int_req_o | output | 1 | Unmasked interrupt request |

## Verification
The hardest cases to reach are those where a carry-in or borrow-in decides the flags. Examples are ADC on 0xFF+0x00 with C set, SBC across zero, and a rotate whose outgoing carry feeds the next rotate. In each of these, the outcome depends on flag state that earlier operations left behind. The stimulus therefore runs long random sequences in which set-carry and clear-carry codes appear among the arithmetic. It also adds directed chains that set the carry first and then run the boundary operands, and that alternate the mask while the request line toggles.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
   typedef enum logic [4:0] {
      OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
      OP_INC = 5'd4,  OP_DEC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
      OP_XOR = 5'd8,  OP_NOT = 5'd9,  OP_SHL = 5'd10, OP_SHR = 5'd11,
      OP_ASR = 5'd12, OP_ROL = 5'd13, OP_ROR = 5'd14, OP_CLC = 5'd15,
      OP_SEC = 5'd16, OP_CLV = 5'd17, OP_SEV = 5'd18, OP_CLI = 5'd19,
      OP_SEI = 5'd20, OP_TAP = 5'd21, OP_TPA = 5'd22
   } alu_op_e;

   localparam int FC = 0;
   localparam int FV = 1;
   localparam int FZ = 2;
   localparam int FN = 3;
   localparam int FI = 4;
   localparam int FH = 5;
   localparam int CCR_W = 8;
   localparam int FLAG_N = 6;
   localparam logic [CCR_W-1:0] CCR_RST = 8'hD0;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
   parameter int W  = 8,
   parameter int HB = 4
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         half,
   output logic         ovf
);
   logic [W:0] full;

   generate
      if (HB < 1 || HB >= W) begin : g_bad_hb
         $error("alu8_addsub: HB must lie inside the word");
      end
   endgenerate

   assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
   assign sum  = full[W-1:0];
   assign cout = full[W];
   // carry into bit HB recovered from the sum bit and the two operand bits
   assign half = x[HB] ^ y[HB] ^ full[HB];
   assign ovf  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift #(
   parameter int W         = 8,
   parameter bit ROT_THR_C = 1'b1
) (
   input  logic [W-1:0] a,
   input  logic [2:0]   sel,
   input  logic         cin,
   output logic [W-1:0] res,
   output logic         cout
);
   logic fill_l;
   logic fill_r;

   generate
      if (ROT_THR_C) begin : g_thru_carry
         assign fill_l = cin;
         assign fill_r = cin;
      end else begin : g_circular
         assign fill_l = a[W-1];
         assign fill_r = a[0];
      end
   endgenerate

   always_comb begin
      res  = a;
      cout = 1'b0;
      case (sel)
         3'd0: begin res = {a[W-2:0], 1'b0};     cout = a[W-1]; end
         3'd1: begin res = {1'b0, a[W-1:1]};     cout = a[0];   end
         3'd2: begin res = {a[W-1], a[W-1:1]};   cout = a[0];   end
         3'd3: begin res = {a[W-2:0], fill_l};   cout = a[W-1]; end
         3'd4: begin res = {fill_r, a[W-1:1]};   cout = a[0];   end
         default: begin res = a; cout = cin; end
      endcase
   end
endmodule

// File: rtl/alu8_ccr_reg.sv
module alu8_ccr_reg
   import alu8_pkg::*;
#(
   parameter logic [CCR_W-1:0] RST_VAL = CCR_RST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [FLAG_N-1:0] d,
   output logic [CCR_W-1:0]  q
);
   localparam int PAD = CCR_W - FLAG_N;

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= RST_VAL;
      else if (load) q <= {{PAD{1'b1}}, d};
   end
endmodule

// File: rtl/alu8_ccr.sv
module alu8_ccr
   import alu8_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter bit ROT_THR_C = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid_i,
   input  logic [4:0]        op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              irq_n_i,
   output logic [DATA_W-1:0] result_o,
   output logic [CCR_W-1:0]  ccr_o,
   output logic              int_mask_o,
   output logic              int_req_o
);
   localparam int HB = DATA_W / 2;
   localparam logic [4:0] SHIFT_BASE = 5'(OP_SHL);

   generate
      if (DATA_W < CCR_W || (DATA_W % 2) != 0) begin : g_bad_w
         $error("alu8_ccr: DATA_W must be even and at least 8");
      end
   endgenerate

   alu_op_e            op_e;
   logic [CCR_W-1:0]   ccr_q;
   logic [CCR_W-1:0]   nxt;
   logic [DATA_W-1:0]  ax, ay, sum, sh_res, res;
   logic               cin, cout, half, ovf, sh_c, upd_nz;
   logic [2:0]         sh_sel;

   assign op_e   = alu_op_e'(op_i);
   assign sh_sel = 3'(op_i - SHIFT_BASE);

   // operand steering for the shared adder
   always_comb begin
      ax  = a_i;
      ay  = b_i;
      cin = 1'b0;
      case (op_e)
         OP_ADC:  cin = ccr_q[FC];
         OP_SUB:  begin ay = ~b_i; cin = 1'b1; end
         OP_SBC:  begin ay = ~b_i; cin = ~ccr_q[FC]; end
         OP_INC:  begin ay = '0;   cin = 1'b1; end
         OP_DEC:  ay = '1;
         default: ;
      endcase
   end

   alu8_addsub #(.W(DATA_W), .HB(HB)) u_add (
      .x(ax), .y(ay), .cin(cin), .sum(sum), .cout(cout), .half(half), .ovf(ovf)
   );

   alu8_shift #(.W(DATA_W), .ROT_THR_C(ROT_THR_C)) u_shf (
      .a(a_i), .sel(sh_sel), .cin(ccr_q[FC]), .res(sh_res), .cout(sh_c)
   );

   // result and flag update
   always_comb begin
      res    = a_i;
      nxt    = ccr_q;
      upd_nz = 1'b1;
      case (op_e)
         OP_ADD, OP_ADC: begin
            res = sum; nxt[FC] = cout; nxt[FV] = ovf; nxt[FH] = half;
         end
         OP_SUB, OP_SBC: begin
            res = sum; nxt[FC] = ~cout; nxt[FV] = ovf;
         end
         OP_INC, OP_DEC: begin
            res = sum; nxt[FV] = ovf;
         end
         OP_AND: begin res = a_i & b_i; nxt[FV] = 1'b0; end
         OP_OR:  begin res = a_i | b_i; nxt[FV] = 1'b0; end
         OP_XOR: begin res = a_i ^ b_i; nxt[FV] = 1'b0; end
         OP_NOT: begin res = ~a_i;      nxt[FV] = 1'b0; end
         OP_SHL, OP_SHR, OP_ASR, OP_ROL, OP_ROR: begin
            res = sh_res; nxt[FC] = sh_c; nxt[FV] = sh_res[DATA_W-1] ^ sh_c;
         end
         OP_CLC: begin upd_nz = 1'b0; nxt[FC] = 1'b0; end
         OP_SEC: begin upd_nz = 1'b0; nxt[FC] = 1'b1; end
         OP_CLV: begin upd_nz = 1'b0; nxt[FV] = 1'b0; end
         OP_SEV: begin upd_nz = 1'b0; nxt[FV] = 1'b1; end
         OP_CLI: begin upd_nz = 1'b0; nxt[FI] = 1'b0; end
         OP_SEI: begin upd_nz = 1'b0; nxt[FI] = 1'b1; end
         OP_TAP: begin upd_nz = 1'b0; nxt[FLAG_N-1:0] = a_i[FLAG_N-1:0]; end
         OP_TPA: begin upd_nz = 1'b0; res = DATA_W'(ccr_q); end
         default: upd_nz = 1'b0;
      endcase
      if (upd_nz) begin
         nxt[FN] = res[DATA_W-1];
         nxt[FZ] = (res == '0);
      end
   end

   alu8_ccr_reg #(.RST_VAL(CCR_RST)) u_ccr (
      .clk(clk), .rst_n(rst_n), .load(op_valid_i), .d(nxt[FLAG_N-1:0]), .q(ccr_q)
   );

   assign result_o   = res;
   assign ccr_o      = ccr_q;
   assign int_mask_o = ccr_q[FI];
   assign int_req_o  = ~irq_n_i & ~ccr_q[FI];

   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid_i |=> $stable(ccr_o)); // R10
   AST_SUB_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_i == OP_SUB) |=> ccr_o[FC] == ($past(b_i) > $past(a_i))); // R3
   AST_INC_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && (op_i == OP_INC || op_i == OP_DEC)) |=> ccr_o[FC] == $past(ccr_o[FC])); // R4
   AST_AND_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_i == OP_AND) |=> ccr_o[FZ] == (($past(a_i) & $past(b_i)) == '0)); // R12
   AST_SEI_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_i == OP_SEI) |=> (int_mask_o && !int_req_o)); // R11
   AST_LOGIC_NO_V: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid_i && op_i == OP_XOR) |=> !ccr_o[FV]); // R5
endmodule

// File: tb/alu8_ccr_test.sv
module alu8_ccr_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       op_valid_i = 1'b0;
   logic [4:0] op_i = '0;
   logic [7:0] a_i = '0, b_i = '0;
   logic       irq_n_i = 1'b1;
   logic [7:0] result_o, ccr_o;
   logic       int_mask_o, int_req_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [7:0] exp_ccr;

   always #4 clk = ~clk;

   alu8_ccr uut (
      .clk(clk), .rst_n(rst_n), .op_valid_i(op_valid_i), .op_i(op_i),
      .a_i(a_i), .b_i(b_i), .irq_n_i(irq_n_i), .result_o(result_o),
      .ccr_o(ccr_o), .int_mask_o(int_mask_o), .int_req_o(int_req_o)
   );

   function automatic string tag_of(input logic [4:0] op);
      if (op <= 1)  return "R2";
      if (op <= 3)  return "R3";
      if (op <= 5)  return "R4";
      if (op <= 9)  return "R5";
      if (op <= 12) return "R6";
      if (op <= 14) return "R7";
      if (op <= 20) return "R8";
      if (op <= 22) return "R9";
      return "R10";
   endfunction

   // reference model: returns {result, next status}
   function automatic logic [15:0] model(input logic [4:0] op, input logic [7:0] a,
                                         input logic [7:0] b, input logic [7:0] f);
      logic [7:0] r;
      logic [7:0] n;
      int s, ss, ci;
      bit nz;
      r = a; n = f; nz = 1'b1;
      ci = f[0] ? 1 : 0;
      case (op)
         5'd0, 5'd1: begin
            if (op == 5'd0) ci = 0;
            s = int'(a) + int'(b) + ci;
            ss = int'($signed(a)) + int'($signed(b)) + ci;
            r = s[7:0]; n[0] = (s > 255); n[1] = (ss > 127 || ss < -128);
            n[5] = ((int'(a) % 16) + (int'(b) % 16) + ci) > 15;
         end
         5'd2, 5'd3: begin
            if (op == 5'd2) ci = 0;
            s = int'(a) - int'(b) - ci;
            ss = int'($signed(a)) - int'($signed(b)) - ci;
            r = s[7:0]; n[0] = (s < 0); n[1] = (ss > 127 || ss < -128);
         end
         5'd4: begin r = a + 8'd1; n[1] = (a == 8'h7F); end
         5'd5: begin r = a - 8'd1; n[1] = (a == 8'h80); end
         5'd6: begin r = a & b; n[1] = 1'b0; end
         5'd7: begin r = a | b; n[1] = 1'b0; end
         5'd8: begin r = a ^ b; n[1] = 1'b0; end
         5'd9: begin r = ~a;    n[1] = 1'b0; end
         5'd10: begin r = a << 1; n[0] = a[7]; end
         5'd11: begin r = a >> 1; n[0] = a[0]; end
         5'd12: begin r = 8'($signed(a) >>> 1); n[0] = a[0]; end
         5'd13: begin r = {a[6:0], f[0]}; n[0] = a[7]; end
         5'd14: begin r = {f[0], a[7:1]}; n[0] = a[0]; end
         5'd15: begin nz = 0; n[0] = 1'b0; end
         5'd16: begin nz = 0; n[0] = 1'b1; end
         5'd17: begin nz = 0; n[1] = 1'b0; end
         5'd18: begin nz = 0; n[1] = 1'b1; end
         5'd19: begin nz = 0; n[4] = 1'b0; end
         5'd20: begin nz = 0; n[4] = 1'b1; end
         5'd21: begin nz = 0; n[5:0] = a[5:0]; end
         5'd22: begin nz = 0; r = f; end
         default: nz = 0;
      endcase
      if (nz) begin
         n[3] = r[7];
         n[2] = (r == 8'h00);
      end
      if (op >= 5'd10 && op <= 5'd14) n[1] = n[3] ^ n[0];
      n[7:6] = 2'b11;
      return {r, n};
   endfunction

   task automatic chk(input string tag, input string what, input logic [7:0] act,
                      input logic [7:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
      end
   endtask

   task automatic step(input logic [4:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic v, input logic irqn);
      logic [15:0] m;
      @(negedge clk);
      op_valid_i = v; op_i = op; a_i = a; b_i = b; irq_n_i = irqn;
      #2;
      m = model(op, a, b, exp_ccr);
      chk(tag_of(op), "result", result_o, m[15:8]);
      chk("R11", "int_req", {7'd0, int_req_o}, {7'd0, ~irqn & ~exp_ccr[4]});
      @(posedge clk);
      #1;
      if (v) exp_ccr = m[7:0];
      chk(v ? tag_of(op) : "R10", "status", ccr_o, exp_ccr);
      chk("R11", "int_mask", {7'd0, int_mask_o}, {7'd0, exp_ccr[4]});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h00C0FFEE));
      repeat (3) @(posedge clk);
      #1;
      exp_ccr = 8'hD0;
      chk("R1", "reset status", ccr_o, 8'hD0);
      chk("R1", "reset mask", {7'd0, int_mask_o}, 8'h01);
      @(negedge clk);
      rst_n = 1'b1;

      // R11: masked request is blocked, then unmasked
      step(5'd0, 8'h00, 8'h00, 1'b0, 1'b0);
      step(5'd19, 8'h00, 8'h00, 1'b1, 1'b0);   // CLI
      step(5'd0, 8'h00, 8'h00, 1'b0, 1'b0);
      step(5'd20, 8'h00, 8'h00, 1'b1, 1'b0);   // SEI
      // R2 corner cases
      step(5'd0, 8'h7F, 8'h01, 1'b1, 1'b1);
      step(5'd0, 8'hFF, 8'h01, 1'b1, 1'b1);
      step(5'd16, 8'h00, 8'h00, 1'b1, 1'b1);   // SEC
      step(5'd1, 8'hFF, 8'h00, 1'b1, 1'b1);    // ADC with carry in
      // R3 corner cases
      step(5'd2, 8'h00, 8'h01, 1'b1, 1'b1);
      step(5'd3, 8'h80, 8'h00, 1'b1, 1'b1);    // SBC with borrow in
      step(5'd2, 8'h80, 8'h01, 1'b1, 1'b1);
      // R4
      step(5'd16, 8'h00, 8'h00, 1'b1, 1'b1);
      step(5'd4, 8'h7F, 8'h00, 1'b1, 1'b1);
      step(5'd5, 8'h80, 8'h00, 1'b1, 1'b1);
      step(5'd4, 8'hFF, 8'h00, 1'b1, 1'b1);
      // R6, R7 chained carry
      step(5'd11, 8'h01, 8'h00, 1'b1, 1'b1);
      step(5'd13, 8'h80, 8'h00, 1'b1, 1'b1);
      step(5'd14, 8'h00, 8'h00, 1'b1, 1'b1);
      step(5'd12, 8'h81, 8'h00, 1'b1, 1'b1);
      // R8, R5
      step(5'd18, 8'h00, 8'h00, 1'b1, 1'b1);
      step(5'd6, 8'hF0, 8'h0F, 1'b1, 1'b1);
      step(5'd17, 8'h00, 8'h00, 1'b1, 1'b1);
      // R9, R12: zeros loaded, top bits stay set
      step(5'd21, 8'h00, 8'h00, 1'b1, 1'b1);
      chk("R12", "top bits", {6'd0, ccr_o[7:6]}, 8'h03);
      step(5'd21, 8'h3F, 8'h00, 1'b1, 1'b1);
      step(5'd22, 8'h12, 8'h00, 1'b1, 1'b1);
      // R10: idle strobe and unused codes
      step(5'd15, 8'h00, 8'h00, 1'b0, 1'b1);
      step(5'd25, 8'h00, 8'h00, 1'b1, 1'b1);
      step(5'd31, 8'hAA, 8'h55, 1'b1, 1'b1);

      for (int i = 0; i < 4000; i++) begin
         logic [4:0] op;
         op = 5'($urandom_range(0, 24));
         step(op, 8'($urandom), 8'($urandom), ($urandom % 8) != 0, 1'($urandom));
      end

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule